// File: doc/BRIEF.md
# Jitter-Tolerant Horizontal Sync Regenerator

This block sits behind a video link receiver and rebuilds clean horizontal and vertical sync outputs. Some transmitters let the raw horizontal sync pulse wander by one pixel clock either way from line to line. The data-enable signal keeps a fixed relation to the pixel data, so the block uses it as the timing reference. On each line it measures where the raw sync pulse starts and how long it lasts, both counted from the falling edge of data enable. It rounds both numbers to the nearest multiple of eight pixel clocks and then drives its own sync pulse at the rounded position on every line.

A rounded measurement is adopted only after two consecutive lines agree on it, so a single disturbed line cannot move the output. The adopted values take effect at the next falling edge of data enable. Vertical sync is re-timed so that it changes state only at the leading edge of the regenerated horizontal pulse. A bypass input turns regeneration off and passes both raw sync inputs through a single register stage. All sync signals are active high.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, both sync outputs are low, and no regenerated pulse appears until two lines have agreed (see R5).
- R2: Offset is the number of pixel clocks from the first cycle in which data enable is low to the first cycle in which raw horizontal sync is high. It is rounded to the nearest multiple of 8, and a value that lies exactly halfway (remainder 4) rounds down, so 12 becomes 8 and 13 becomes 16.
- R3: Pulse width is the number of cycles raw horizontal sync stays high. It is rounded the same way as the offset, and a result of 0 is raised to 8.
- R4: A raw pulse that moves between offsets N-1, N and N+1, where N is a multiple of 8, gives a regenerated pulse at offset N on every line.
- R5: A rounded offset and width pair is adopted only when two consecutive lines produce the same pair. It takes effect from the next falling edge of data enable.
- R6: A single line whose rounded pair differs from its neighbours does not change the regenerated pulse.
- R7: The regenerated horizontal sync goes high one clock after the cycle at the adopted offset and stays high for the adopted width. When the raw pulse already sits on the grid and has a multiple-of-8 width, the output is the raw pulse delayed by one clock.
- R8: With bypass low, vertical sync output changes only on the clock at which regenerated horizontal sync rises, and it takes the raw vertical sync level of that cycle.
- R9: With bypass high, each sync output equals its raw input delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | High: raw syncs pass through one register stage |
| de | input | 1 | Data enable, timing reference |
| hsync_in | input | 1 | Raw horizontal sync, may jitter by one clock |
| vsync_in | input | 1 | Raw vertical sync |
| hsync_out | output | 1 | Regenerated horizontal sync |
| vsync_out | output | 1 | Re-timed vertical sync |

## Verification
The main collision is between adopting a new offset and generating the pulse on the same line. The agreeing measurement completes at the raw falling edge, which can lie inside or past the current window. Adoption is therefore deferred to the next falling edge of data enable. The bench provokes this with a lasting move from offset 16 to offset 24 and checks that the line on which the agreement forms still carries exactly one pulse at the old offset, and that the next line carries one pulse at the new offset. A second overlap is a vertical sync change in the same line as the regenerated horizontal edge. The bench checks the vertical output one sample before the edge and again at the edge.

// File: rtl/hsr_pkg.sv
// Shared constants and the grid-rounding function for the sync regenerator.
// Assumes the snapping grid is a power of two.
package hsr_pkg;
    localparam int unsigned GRID_LOG2 = 3;
    localparam int unsigned GRID      = 1 << GRID_LOG2;
    localparam int unsigned HALF_M1   = (GRID / 2) - 1;

    // Round to nearest grid multiple, halfway rounds down; optional floor of one grid step.
    function automatic logic [31:0] snap_grid(input logic [31:0] v, input logic min_one);
        logic [31:0] s;
        s = v + HALF_M1;
        s[GRID_LOG2-1:0] = '0;
        if (min_one && s == 32'd0) s = GRID;
        return s;
    endfunction
endpackage

// File: rtl/hsr_meter.sv
// Measures the raw horizontal sync offset and width relative to the
// falling edge of data enable, and reports grid-rounded values once per line.
// Assumes one raw sync pulse per line, lying inside the line counter range.
module hsr_meter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    input  logic             hsync_in,
    output logic [CNT_W-1:0] idx,
    output logic             de_fall,
    output logic             line_done,
    output logic [CNT_W-1:0] off_snap,
    output logic [CNT_W-1:0] wid_snap
);
    import hsr_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             de_q, hs_q, seen_q;
    logic [CNT_W-1:0] pos_q, off_q, wid_raw;
    logic             hs_rise, hs_fall;

    assign de_fall   = de_q & ~de;
    assign idx       = de_fall ? '0 : pos_q;
    assign hs_rise   = hsync_in & ~hs_q;
    assign hs_fall   = ~hsync_in & hs_q;
    assign line_done = hs_fall & seen_q;
    assign wid_raw   = idx - off_q;
    assign off_snap  = CNT_W'(snap_grid(32'(off_q), 1'b0));
    assign wid_snap  = CNT_W'(snap_grid(32'(wid_raw), 1'b1));

    // Edge history and saturating line-position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q  <= 1'b0;
            hs_q  <= 1'b0;
            pos_q <= '0;
        end else begin
            de_q  <= de;
            hs_q  <= hsync_in;
            pos_q <= (idx == CNT_MAX) ? idx : idx + 1'b1;
        end
    end

    // Capture the offset at the raw leading edge; track an open pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            seen_q <= 1'b0;
        end else if (hs_rise) begin
            off_q  <= idx;
            seen_q <= 1'b1;
        end else if (hs_fall) begin
            seen_q <= 1'b0;
        end
    end

    // R2 R3
    snapped_on_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (off_snap[GRID_LOG2-1:0] == '0 && wid_snap[GRID_LOG2-1:0] == '0
                       && wid_snap != '0));
endmodule

// File: rtl/hsr_filter.sv
// Two-line agreement filter: a rounded offset/width pair becomes pending
// only when it repeats on consecutive lines; pending values become active
// at the next data-enable falling edge. Assumes line_done and de_fall never coincide.
module hsr_filter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_done,
    input  logic             de_fall,
    input  logic [CNT_W-1:0] off_snap,
    input  logic [CNT_W-1:0] wid_snap,
    output logic             eff_valid,
    output logic [CNT_W-1:0] eff_off,
    output logic [CNT_W-1:0] eff_wid
);
    logic             cand_valid, pend_valid, act_valid;
    logic [CNT_W-1:0] cand_off, cand_wid, pend_off, pend_wid, act_off, act_wid;
    logic             agree;

    assign agree     = cand_valid && off_snap == cand_off && wid_snap == cand_wid;
    assign eff_valid = de_fall ? pend_valid : act_valid;
    assign eff_off   = de_fall ? pend_off   : act_off;
    assign eff_wid   = de_fall ? pend_wid   : act_wid;

    // Remember the last line's pair and promote it when the next line agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_off   <= '0;
            cand_wid   <= '0;
            pend_valid <= 1'b0;
            pend_off   <= '0;
            pend_wid   <= '0;
        end else if (line_done) begin
            cand_valid <= 1'b1;
            cand_off   <= off_snap;
            cand_wid   <= wid_snap;
            if (agree) begin
                pend_valid <= 1'b1;
                pend_off   <= off_snap;
                pend_wid   <= wid_snap;
            end
        end
    end

    // Load the pending pair at the start of each line so the window never shifts mid-line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_off   <= '0;
            act_wid   <= '0;
        end else if (de_fall) begin
            act_valid <= pend_valid;
            act_off   <= pend_off;
            act_wid   <= pend_wid;
        end
    end

    // R5 R6
    no_commit_without_agreement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && !agree) |=> ($stable(pend_off) && $stable(pend_wid)));
endmodule

// File: rtl/hsr_gen.sv
// Output stage: draws the regenerated horizontal pulse from the line
// position and the active window, re-times vertical sync to its leading
// edge, or passes raw syncs through in bypass. Outputs are registered.
module hsr_gen #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [CNT_W-1:0] idx,
    input  logic             eff_valid,
    input  logic [CNT_W-1:0] eff_off,
    input  logic [CNT_W-1:0] eff_wid,
    output logic             hsync_out,
    output logic             vsync_out
);
    logic [CNT_W:0] win_end;
    logic           hs_next;

    assign win_end = {1'b0, eff_off} + {1'b0, eff_wid};
    assign hs_next = eff_valid && (idx >= eff_off) && ({1'b0, idx} < win_end);

    // Drive the registered sync outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_out <= 1'b0;
            vsync_out <= 1'b0;
        end else if (bypass) begin
            hsync_out <= hsync_in;
            vsync_out <= vsync_in;
        end else begin
            hsync_out <= hs_next;
            if (hs_next && !hsync_out) vsync_out <= vsync_in;
        end
    end

    // R9
    bypass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (hsync_out == $past(hsync_in) && vsync_out == $past(vsync_in)));

    // R8
    vsync_moves_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vsync_out) && !$past(bypass)) |-> $rose(hsync_out));
endmodule

// File: rtl/hsync_regen.sv
// Top of the jitter-tolerant sync regenerator: meter, agreement filter and
// output stage. Assumes active-high syncs and one raw pulse per line in blanking.
module hsync_regen #(
    parameter int unsigned CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic de,
    input  logic hsync_in,
    input  logic vsync_in,
    output logic hsync_out,
    output logic vsync_out
);
    logic [CNT_W-1:0] idx, off_snap, wid_snap, eff_off, eff_wid;
    logic             de_fall, line_done, eff_valid;

    hsr_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .de(de), .hsync_in(hsync_in),
        .idx(idx), .de_fall(de_fall), .line_done(line_done),
        .off_snap(off_snap), .wid_snap(wid_snap)
    );

    hsr_filter #(.CNT_W(CNT_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .line_done(line_done), .de_fall(de_fall),
        .off_snap(off_snap), .wid_snap(wid_snap),
        .eff_valid(eff_valid), .eff_off(eff_off), .eff_wid(eff_wid)
    );

    hsr_gen #(.CNT_W(CNT_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .idx(idx),
        .eff_valid(eff_valid), .eff_off(eff_off), .eff_wid(eff_wid),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!hsync_out && !vsync_out));
endmodule

// File: tb/hsync_regen_test.sv
module hsync_regen_test;
    localparam int BLANK = 48;
    localparam int ACTIVE = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic de = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic hsync_out, vsync_out;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    hsync_regen uut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .de(de),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset, then one active period so the next line starts with a DE fall.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; de = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0; bypass = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        de = 1'b1;
        repeat (ACTIVE - 1) @(negedge clk);
    endtask

    // One line: blanking with the raw pulse, then active. Returns observed pulse data;
    // sample at step i reflects the design's position i-1.
    task automatic drive_line(input int o, input int w, input bit v,
                              output int rise, output int cnt, output bit vpre, output bit vat);
        bit last_vs;
        rise = -1; cnt = 0; vpre = 1'b0; vat = 1'b0; last_vs = vsync_out;
        for (int i = 0; i < BLANK + ACTIVE; i++) begin
            @(negedge clk);
            if (i > 0 && hsync_out) begin
                if (rise < 0) begin
                    rise = i - 1; vat = vsync_out; vpre = last_vs;
                end
                cnt++;
            end
            last_vs = vsync_out;
            de = (i >= BLANK);
            hsync_in = (i >= o && i < o + w);
            vsync_in = v;
        end
    endtask

    task automatic expect_line(input int o, input int w, input int erise, input int ecnt,
                               input string req);
        int r, c; bit vp, va;
        drive_line(o, w, 1'b0, r, c, vp, va);
        chk(r == erise, req, r, erise);
        chk(c == ecnt, req, c, ecnt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!hsync_out && !vsync_out, "R1 outputs low in reset", hsync_out, 0);
        do_reset();
        chk(!hsync_out && !vsync_out, "R1 outputs low after reset", hsync_out, 0);
    endtask

    task automatic t_aligned();
        do_reset();
        expect_line(16, 8, -1, 0, "R1 no pulse before agreement");
        expect_line(16, 8, -1, 0, "R5 adopted only from next line");
        expect_line(16, 8, 16, 8, "R7 aligned input equals raw delayed");
        expect_line(16, 8, 16, 8, "R7 aligned steady");
    endtask

    task automatic t_jitter();
        do_reset();
        expect_line(15, 8, -1, 0, "R4 jitter line1");
        expect_line(17, 8, -1, 0, "R4 jitter line2");
        expect_line(16, 8, 16, 8, "R4 jitter nominal");
        expect_line(15, 8, 16, 8, "R4 jitter early");
        expect_line(17, 8, 16, 8, "R4 jitter late");
    endtask

    task automatic t_rounding();
        do_reset();
        expect_line(12, 12, -1, 0, "R2 tie warmup");
        expect_line(12, 12, -1, 0, "R2 tie warmup");
        expect_line(12, 12, 8, 8, "R2 R3 halfway rounds down");
        do_reset();
        expect_line(13, 13, -1, 0, "R2 above-half warmup");
        expect_line(13, 13, -1, 0, "R2 above-half warmup");
        expect_line(13, 13, 16, 16, "R2 R3 above half rounds up");
        do_reset();
        expect_line(16, 2, -1, 0, "R3 narrow warmup");
        expect_line(16, 2, -1, 0, "R3 narrow warmup");
        expect_line(16, 2, 16, 8, "R3 minimum width 8");
    endtask

    task automatic t_glitch_and_move();
        do_reset();
        expect_line(16, 8, -1, 0, "R5 warmup");
        expect_line(16, 8, -1, 0, "R5 warmup");
        expect_line(16, 8, 16, 8, "R5 locked");
        expect_line(30, 8, 16, 8, "R6 glitch line keeps output");
        expect_line(16, 8, 16, 8, "R6 after glitch unchanged");
        expect_line(24, 8, 16, 8, "R5 first new line ignored");
        expect_line(24, 8, 16, 8, "R5 agreeing line keeps one old pulse");
        expect_line(24, 8, 24, 8, "R5 new offset next line");
    endtask

    task automatic t_vsync();
        int r, c; bit vp, va;
        do_reset();
        expect_line(16, 8, -1, 0, "R8 warmup");
        expect_line(16, 8, -1, 0, "R8 warmup");
        drive_line(16, 8, 1'b1, r, c, vp, va);
        chk(r == 16, "R8 edge position", r, 16);
        chk(vp == 1'b0, "R8 vsync held before edge", vp, 0);
        chk(va == 1'b1, "R8 vsync taken at edge", va, 1);
        drive_line(16, 8, 1'b0, r, c, vp, va);
        chk(vp == 1'b1 && va == 1'b0, "R8 vsync falls at edge", va, 0);
    endtask

    task automatic t_bypass();
        int r, c; bit vp, va;
        do_reset();
        bypass = 1'b1;
        drive_line(15, 9, 1'b1, r, c, vp, va);
        chk(r == 15, "R9 bypass rise position", r, 15);
        chk(c == 9, "R9 bypass raw width", c, 9);
        chk(va == 1'b1, "R9 bypass vsync follows", va, 1);
        drive_line(17, 5, 1'b0, r, c, vp, va);
        chk(r == 17 && c == 5, "R9 bypass keeps jitter", r, 17);
        bypass = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_aligned();
        t_jitter();
        t_rounding();
        t_glitch_and_move();
        t_vsync();
        t_bypass();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule